// File: doc/BRIEF.md
# Register-Machine Execute Unit

This block carries out one already-decoded instruction of a compact register-machine instruction set. It holds its own eight-entry, 32-bit register file and drives a word-wide data memory port. The fetch logic presents the opcode, three 4-bit operand fields, an 8-bit immediate and a 32-bit extension word, then pulses `start_i`. The unit captures those fields, performs the operation and pulses `done_o` when the operation has finished.

Operations that only touch registers finish in the cycle after the start. Stores also finish in that cycle, with the write request issued in the same cycle. Loads put out a read request in that cycle and write the returned word one cycle later. Every register write is visible on the write-port outputs. A halt operation stops the unit until reset. An undefined encoding, or a register number outside the file, raises `illegal_o` together with `done_o` and changes no state.

Top module: `rm_exec_unit`

## Requirements
- R1: After reset `done_o`, `reg_we_o`, `mem_req_o`, `halt_o` and `illegal_o` are 0, and all registers hold 0.
- R2: Opcode 0x0 writes `ext_i` into the register named by operand 0, and `done_o` is 1 in the cycle after the start.
- R3: Opcode 0x1 reads the word at R[operand1] + 4*operand0 into R[operand2]. The read request is issued in the cycle after the start, and the register write, with `done_o`, follows one cycle later using `mem_rdata_i`.
- R4: Opcode 0x3 writes R[operand0] to address R[operand2] + 4*operand1. The write request and `done_o` occur in the cycle after the start, and no register is written.
- R5: Indexed forms scale the index register by 4. Opcode 0x2 loads R[op0] + 4*R[op1] into R[op2]. Opcode 0x4 stores R[op0] to R[op1] + 4*R[op2]. Both use the same timing as R3 and R4.
- R6: Opcode 0x6 uses operand 0 to select the function. Values 0, 1 and 2 are move, add and AND, with R[op1] as source and R[op2] as destination. Values 3 to 7 are +1, +4, -1, -4 and bitwise NOT applied to R[op2]. All arithmetic wraps modulo 2^32.
- R7: Opcode 0x6 with an operand 0 value of 8 or more is illegal.
- R8: Opcode 0x7 treats the immediate as signed. A positive value shifts R[op0] left by that amount. Zero or a negative value shifts it arithmetically right by the magnitude. A shift of 32 or more gives 0 (left) or copies of the sign bit (right).
- R9: Opcode 0xF with operand 0 = 0 halts the unit. `halt_o` rises one cycle after that operation's `done_o` and stays high until reset, and every later start is ignored.
- R10: Opcode 0xF with a nonzero operand 0 is a no-op. It raises `done_o` with no register write and no memory request.
- R11: The opcodes 0x5 and 0x8 to 0xE are illegal, and so is any register operand above 7. An illegal instruction raises `illegal_o` and `done_o` for one cycle, with no register write and no memory request.
- R12: A start that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture the instruction fields and begin |
| opcode_i | input | 4 | Decoded opcode |
| op0_i | input | 4 | Operand field 0 |
| op1_i | input | 4 | Operand field 1 |
| op2_i | input | 4 | Operand field 2 |
| imm_i | input | 8 | Immediate (signed for shifts) |
| ext_i | input | 32 | Extension word for immediate loads |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read request |
| reg_we_o | output | 1 | Register write enable |
| reg_waddr_o | output | 3 | Register write index |
| reg_wdata_o | output | 32 | Register write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Store data |
| done_o | output | 1 | Operation finished |
| halt_o | output | 1 | Unit halted |
| illegal_o | output | 1 | Current operation was illegal |

## Verification
The load timing property assumes that the memory always returns data in the cycle after a read request and never inserts wait states. The bench memory model is a plain registered array with exactly that latency. The properties also assume that `start_i` is only meaningful while the unit is idle. The bench drives a start during a load on purpose and checks that it leaves no trace. Every address the bench generates falls inside the 64-word model, so a load always returns a value the bench has written itself.

// File: rtl/rm_exec_pkg.sv
package rm_exec_pkg;

  localparam logic [3:0] OPC_LDI = 4'h0;
  localparam logic [3:0] OPC_LDO = 4'h1;
  localparam logic [3:0] OPC_LDX = 4'h2;
  localparam logic [3:0] OPC_STO = 4'h3;
  localparam logic [3:0] OPC_STX = 4'h4;
  localparam logic [3:0] OPC_ALU = 4'h6;
  localparam logic [3:0] OPC_SHF = 4'h7;
  localparam logic [3:0] OPC_SYS = 4'hf;

  typedef enum logic [2:0] {K_NOP, K_REG, K_LOAD, K_STORE, K_HALT} kind_e;

  typedef enum logic [3:0] {
    F_EXT, F_MOV, F_ADD, F_AND, F_INC1, F_INC4, F_DEC1, F_DEC4, F_NOT, F_SHF
  } fn_e;

  typedef struct packed {
    kind_e      kind;
    fn_e        fn;
    logic       indexed;
    logic       legal;
    logic [3:0] ra;   // base / first source
    logic [3:0] rb;   // index / second source
    logic [3:0] rc;   // store data
    logic [3:0] rd;   // destination
  } dec_t;

endpackage

// File: rtl/rm_decode.sv
module rm_decode
  import rm_exec_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input  logic [3:0] opc_i,
  input  logic [3:0] op0_i,
  input  logic [3:0] op1_i,
  input  logic [3:0] op2_i,
  output dec_t       dec_o
);

  logic bad, u0, u1, u2;

  always_comb begin
    dec_o         = '0;
    dec_o.kind    = K_NOP;
    dec_o.fn      = F_EXT;
    bad           = 1'b0;
    {u0, u1, u2}  = 3'b000;
    case (opc_i)
      OPC_LDI: begin
        dec_o.kind = K_REG; dec_o.rd = op0_i; u0 = 1'b1;
      end
      OPC_LDO: begin
        dec_o.kind = K_LOAD; dec_o.ra = op1_i; dec_o.rd = op2_i;
        {u1, u2} = 2'b11;
      end
      OPC_LDX: begin
        dec_o.kind = K_LOAD; dec_o.indexed = 1'b1;
        dec_o.ra = op0_i; dec_o.rb = op1_i; dec_o.rd = op2_i;
        {u0, u1, u2} = 3'b111;
      end
      OPC_STO: begin
        dec_o.kind = K_STORE; dec_o.ra = op2_i; dec_o.rc = op0_i;
        {u0, u2} = 2'b11;
      end
      OPC_STX: begin
        dec_o.kind = K_STORE; dec_o.indexed = 1'b1;
        dec_o.ra = op1_i; dec_o.rb = op2_i; dec_o.rc = op0_i;
        {u0, u1, u2} = 3'b111;
      end
      OPC_ALU: begin
        dec_o.kind = K_REG; dec_o.rd = op2_i; dec_o.rb = op2_i; u2 = 1'b1;
        dec_o.ra = op2_i;
        case (op0_i)
          4'd0: begin dec_o.fn = F_MOV; dec_o.ra = op1_i; u1 = 1'b1; end
          4'd1: begin dec_o.fn = F_ADD; dec_o.ra = op1_i; u1 = 1'b1; end
          4'd2: begin dec_o.fn = F_AND; dec_o.ra = op1_i; u1 = 1'b1; end
          4'd3: dec_o.fn = F_INC1;
          4'd4: dec_o.fn = F_INC4;
          4'd5: dec_o.fn = F_DEC1;
          4'd6: dec_o.fn = F_DEC4;
          4'd7: dec_o.fn = F_NOT;
          default: bad = 1'b1;
        endcase
      end
      OPC_SHF: begin
        dec_o.kind = K_REG; dec_o.fn = F_SHF;
        dec_o.ra = op0_i; dec_o.rd = op0_i; u0 = 1'b1;
      end
      OPC_SYS: dec_o.kind = (op0_i == 4'd0) ? K_HALT : K_NOP;
      default: bad = 1'b1;
    endcase
    dec_o.legal = !bad
                  && !(u0 && (int'(op0_i) >= int'(NREG)))
                  && !(u1 && (int'(op1_i) >= int'(NREG)))
                  && !(u2 && (int'(op2_i) >= int'(NREG)));
  end

endmodule

// File: rtl/rm_regfile.sv
module rm_regfile #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_i,
  input  logic [IDX_W-1:0]  rb_i,
  input  logic [IDX_W-1:0]  rc_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] c_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i
);

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (we_i && (waddr_i == IDX_W'(g)))      regs_q[g] <= wdata_i;
    end
  end

  assign a_o = regs_q[ra_i];
  assign b_o = regs_q[rb_i];
  assign c_o = regs_q[rc_i];

endmodule

// File: rtl/rm_alu.sv
module rm_alu
  import rm_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  fn_e               fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [7:0]        imm_i,
  input  logic [DATA_W-1:0] ext_i,
  output logic [DATA_W-1:0] res_o
);

  logic       shl;
  logic [8:0] ramt;

  assign shl  = !imm_i[7] && (imm_i != 8'd0);
  assign ramt = 9'd0 - {imm_i[7], imm_i};   // magnitude for zero/negative

  always_comb begin
    case (fn_i)
      F_EXT:   res_o = ext_i;
      F_MOV:   res_o = a_i;
      F_ADD:   res_o = a_i + b_i;
      F_AND:   res_o = a_i & b_i;
      F_INC1:  res_o = a_i + DATA_W'(1);
      F_INC4:  res_o = a_i + DATA_W'(4);
      F_DEC1:  res_o = a_i - DATA_W'(1);
      F_DEC4:  res_o = a_i - DATA_W'(4);
      F_NOT:   res_o = ~a_i;
      F_SHF:   res_o = shl ? (a_i << imm_i[6:0])
                           : DATA_W'($signed(a_i) >>> ramt);
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/rm_agu.sv
module rm_agu #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] idx_i,
  input  logic [3:0]        offs_i,
  input  logic              indexed_i,
  output logic [DATA_W-1:0] addr_o
);

  logic [DATA_W-1:0] disp;

  assign disp   = indexed_i ? (idx_i << 2) : DATA_W'({offs_i, 2'b00});
  assign addr_o = base_i + disp;

endmodule

// File: rtl/rm_exec_unit.sv
module rm_exec_unit
  import rm_exec_pkg::*;
#(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        opcode_i,
  input  logic [3:0]        op0_i,
  input  logic [3:0]        op1_i,
  input  logic [3:0]        op2_i,
  input  logic [7:0]        imm_i,
  input  logic [DATA_W-1:0] ext_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              reg_we_o,
  output logic [IDX_W-1:0]  reg_waddr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              done_o,
  output logic              halt_o,
  output logic              illegal_o
);

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_LWB} state_e;

  state_e            st_q, st_d;
  logic              halted_q;
  logic [3:0]        opc_q, op0_q, op1_q, op2_q;
  logic [7:0]        imm_q;
  logic [DATA_W-1:0] ext_q;
  dec_t              dec;
  logic [DATA_W-1:0] a, b, c, alu_res, addr;
  logic              exec, wb, accept, is_load, is_store;

  assign accept = (st_q == S_IDLE) && start_i && !halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q <= '0; op0_q <= '0; op1_q <= '0; op2_q <= '0;
      imm_q <= '0; ext_q <= '0;
    end else if (accept) begin
      opc_q <= opcode_i; op0_q <= op0_i; op1_q <= op1_i; op2_q <= op2_i;
      imm_q <= imm_i;    ext_q <= ext_i;
    end
  end

  rm_decode #(.NREG(NREG)) i_decode (
    .opc_i(opc_q), .op0_i(op0_q), .op1_i(op1_q), .op2_i(op2_q), .dec_o(dec)
  );

  rm_regfile #(.NREG(NREG), .DATA_W(DATA_W)) i_regfile (
    .clk_i, .rst_ni,
    .ra_i(dec.ra[IDX_W-1:0]), .rb_i(dec.rb[IDX_W-1:0]), .rc_i(dec.rc[IDX_W-1:0]),
    .a_o(a), .b_o(b), .c_o(c),
    .we_i(reg_we_o), .waddr_i(reg_waddr_o), .wdata_i(reg_wdata_o)
  );

  rm_alu #(.DATA_W(DATA_W)) i_alu (
    .fn_i(dec.fn), .a_i(a), .b_i(b), .imm_i(imm_q), .ext_i(ext_q), .res_o(alu_res)
  );

  // base+offset forms carry the word offset in op0 (load) or op1 (store)
  rm_agu #(.DATA_W(DATA_W)) i_agu (
    .base_i(a), .idx_i(b), .offs_i(dec.kind == K_LOAD ? op0_q : op1_q),
    .indexed_i(dec.indexed), .addr_o(addr)
  );

  assign exec     = (st_q == S_EXEC);
  assign wb       = (st_q == S_LWB);
  assign is_load  = dec.legal && (dec.kind == K_LOAD);
  assign is_store = dec.legal && (dec.kind == K_STORE);

  assign reg_we_o    = wb || (exec && dec.legal && (dec.kind == K_REG));
  assign reg_waddr_o = dec.rd[IDX_W-1:0];
  assign reg_wdata_o = wb ? mem_rdata_i : alu_res;
  assign mem_req_o   = exec && (is_load || is_store);
  assign mem_we_o    = exec && is_store;
  assign mem_addr_o  = addr;
  assign mem_wdata_o = c;
  assign done_o      = wb || (exec && !is_load);
  assign illegal_o   = exec && !dec.legal;
  assign halt_o      = halted_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (accept) st_d = S_EXEC;
      S_EXEC:  st_d = is_load ? S_LWB : S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      halted_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (exec && dec.legal && (dec.kind == K_HALT)) halted_q <= 1'b1;
    end
  end

  a_r3_load_writes_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> (reg_we_o && done_o && !mem_req_o));

  a_r4_store_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (done_o && !reg_we_o));

  a_r11_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (done_o && !reg_we_o && !mem_req_o));

  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  a_r9_halt_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (!done_o && !reg_we_o && !mem_req_o));

  a_r12_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: tb/test_rm_exec_unit.sv
module test_rm_exec_unit;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  opcode_i = '0, op0_i = '0, op1_i = '0, op2_i = '0;
  logic [7:0]  imm_i = '0;
  logic [31:0] ext_i = '0;
  logic [31:0] mem_rdata_i = '0;
  logic        reg_we_o, mem_req_o, mem_we_o, done_o, halt_o, illegal_o;
  logic [2:0]  reg_waddr_o;
  logic [31:0] reg_wdata_o, mem_addr_o, mem_wdata_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] mem [64];

  always #5 clk_i = ~clk_i;

  rm_exec_unit i_rm_exec_unit (
    .clk_i, .rst_ni, .start_i, .opcode_i, .op0_i, .op1_i, .op2_i, .imm_i, .ext_i,
    .mem_rdata_i, .reg_we_o, .reg_waddr_o, .reg_wdata_o, .mem_req_o, .mem_we_o,
    .mem_addr_o, .mem_wdata_o, .done_o, .halt_o, .illegal_o
  );

  // one-cycle-latency word memory
  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
      else          mem_rdata_i <= mem[mem_addr_o[7:2]];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] opc, o0, o1, o2, input logic [7:0] imm,
                       input logic [31:0] ext);
    @(negedge clk_i);
    opcode_i = opc; op0_i = o0; op1_i = o1; op2_i = o2; imm_i = imm; ext_i = ext;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic reg_op(input string req, input logic [3:0] opc, o0, o1, o2,
                        input logic [7:0] imm, input logic [31:0] ext,
                        input logic [2:0] rd, input logic [31:0] exp);
    issue(opc, o0, o1, o2, imm, ext);
    chk(req, "done", 32'(done_o), 32'd1);
    chk(req, "reg_we", 32'(reg_we_o), 32'd1);
    chk(req, "waddr", 32'(reg_waddr_o), 32'(rd));
    chk(req, "wdata", reg_wdata_o, exp);
    chk(req, "mem_req", 32'(mem_req_o), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1", "done", 32'(done_o), 32'd0);
    chk("R1", "reg_we", 32'(reg_we_o), 32'd0);
    chk("R1", "mem_req", 32'(mem_req_o), 32'd0);
    chk("R1", "halt", 32'(halt_o), 32'd0);
    chk("R1", "illegal", 32'(illegal_o), 32'd0);
    reg_op("R1", 4'h6, 4'd0, 4'd3, 4'd4, 8'h0, 32'h0, 3'd4, 32'h0); // mov r3->r4 reads 0
  endtask

  task automatic t_ldi;
    reg_op("R2", 4'h0, 4'd1, 4'd0, 4'd0, 8'h0, 32'h1234_5678, 3'd1, 32'h1234_5678);
    reg_op("R2", 4'h0, 4'd2, 4'd0, 4'd0, 8'h0, 32'h0000_0020, 3'd2, 32'h0000_0020);
    reg_op("R2", 4'h0, 4'd3, 4'd0, 4'd0, 8'h0, 32'h0000_0002, 3'd3, 32'h0000_0002);
    reg_op("R2", 4'h0, 4'd5, 4'd0, 4'd0, 8'h0, 32'hFFFF_FFFF, 3'd5, 32'hFFFF_FFFF);
    reg_op("R2", 4'h0, 4'd6, 4'd0, 4'd0, 8'h0, 32'h0000_0003, 3'd6, 32'h0000_0003);
  endtask

  task automatic t_offset;
    issue(4'h3, 4'd1, 4'd3, 4'd2, 8'h0, 32'h0);           // R1 -> 12+R2
    chk("R4", "mem_req", 32'(mem_req_o), 32'd1);
    chk("R4", "mem_we", 32'(mem_we_o), 32'd1);
    chk("R4", "addr", mem_addr_o, 32'h2C);
    chk("R4", "wdata", mem_wdata_o, 32'h1234_5678);
    chk("R4", "done", 32'(done_o), 32'd1);
    chk("R4", "reg_we", 32'(reg_we_o), 32'd0);
    issue(4'h1, 4'd3, 4'd2, 4'd4, 8'h0, 32'h0);           // 12+R2 -> R4
    chk("R3", "mem_req", 32'(mem_req_o), 32'd1);
    chk("R3", "mem_we", 32'(mem_we_o), 32'd0);
    chk("R3", "addr", mem_addr_o, 32'h2C);
    chk("R3", "early done", 32'(done_o), 32'd0);
    chk("R3", "early reg_we", 32'(reg_we_o), 32'd0);
    @(negedge clk_i);
    chk("R3", "reg_we", 32'(reg_we_o), 32'd1);
    chk("R3", "waddr", 32'(reg_waddr_o), 32'd4);
    chk("R3", "wdata", reg_wdata_o, 32'h1234_5678);
    chk("R3", "done", 32'(done_o), 32'd1);
  endtask

  task automatic t_indexed;
    issue(4'h4, 4'd5, 4'd2, 4'd3, 8'h0, 32'h0);           // R5 -> R2 + 4*R3
    chk("R5", "st addr", mem_addr_o, 32'h28);
    chk("R5", "st wdata", mem_wdata_o, 32'hFFFF_FFFF);
    chk("R5", "st we", 32'(mem_we_o), 32'd1);
    issue(4'h2, 4'd2, 4'd3, 4'd0, 8'h0, 32'h0);           // R2 + 4*R3 -> R0
    chk("R5", "ld addr", mem_addr_o, 32'h28);
    chk("R5", "ld we", 32'(mem_we_o), 32'd0);
    @(negedge clk_i);
    chk("R5", "ld waddr", 32'(reg_waddr_o), 32'd0);
    chk("R5", "ld wdata", reg_wdata_o, 32'hFFFF_FFFF);
  endtask

  task automatic t_alu;
    reg_op("R6", 4'h6, 4'd0, 4'd1, 4'd7, 8'h0, 32'h0, 3'd7, 32'h1234_5678); // mov
    reg_op("R6", 4'h6, 4'd1, 4'd5, 4'd6, 8'h0, 32'h0, 3'd6, 32'h0000_0002); // add wraps
    reg_op("R6", 4'h6, 4'd2, 4'd5, 4'd7, 8'h0, 32'h0, 3'd7, 32'h1234_5678); // and
    reg_op("R6", 4'h6, 4'd3, 4'd0, 4'd6, 8'h0, 32'h0, 3'd6, 32'h0000_0003); // +1
    reg_op("R6", 4'h6, 4'd4, 4'd0, 4'd6, 8'h0, 32'h0, 3'd6, 32'h0000_0007); // +4
    reg_op("R6", 4'h6, 4'd5, 4'd0, 4'd6, 8'h0, 32'h0, 3'd6, 32'h0000_0006); // -1
    reg_op("R6", 4'h6, 4'd6, 4'd0, 4'd6, 8'h0, 32'h0, 3'd6, 32'h0000_0002); // -4
    reg_op("R6", 4'h6, 4'd7, 4'd0, 4'd7, 8'h0, 32'h0, 3'd7, 32'hEDCB_A987); // not
    reg_op("R6", 4'h6, 4'd4, 4'd0, 4'd5, 8'h0, 32'h0, 3'd5, 32'h0000_0003); // +4 wraps
    reg_op("R6", 4'h0, 4'd6, 4'd0, 4'd0, 8'h0, 32'h0, 3'd6, 32'h0);
    reg_op("R6", 4'h6, 4'd5, 4'd0, 4'd6, 8'h0, 32'h0, 3'd6, 32'hFFFF_FFFF); // -1 wraps
  endtask

  task automatic bad_op(input string req, input logic [3:0] opc, o0, o1, o2);
    issue(opc, o0, o1, o2, 8'h0, 32'hDEAD_BEEF);
    chk(req, "illegal", 32'(illegal_o), 32'd1);
    chk(req, "done", 32'(done_o), 32'd1);
    chk(req, "reg_we", 32'(reg_we_o), 32'd0);
    chk(req, "mem_req", 32'(mem_req_o), 32'd0);
  endtask

  task automatic t_shift;
    reg_op("R8", 4'h0, 4'd1, 4'd0, 4'd0, 8'h0, 32'h8000_0001, 3'd1, 32'h8000_0001);
    reg_op("R8", 4'h7, 4'd1, 4'd0, 4'd0, 8'h04, 32'h0, 3'd1, 32'h0000_0010);
    reg_op("R8", 4'h0, 4'd1, 4'd0, 4'd0, 8'h0, 32'h8000_0000, 3'd1, 32'h8000_0000);
    reg_op("R8", 4'h7, 4'd1, 4'd0, 4'd0, 8'hFC, 32'h0, 3'd1, 32'hF800_0000);
    reg_op("R8", 4'h7, 4'd1, 4'd0, 4'd0, 8'h00, 32'h0, 3'd1, 32'hF800_0000);
    reg_op("R8", 4'h7, 4'd1, 4'd0, 4'd0, 8'h81, 32'h0, 3'd1, 32'hFFFF_FFFF);
    reg_op("R8", 4'h7, 4'd1, 4'd0, 4'd0, 8'h7F, 32'h0, 3'd1, 32'h0000_0000);
  endtask

  task automatic t_nop;
    issue(4'hF, 4'hF, 4'd0, 4'd0, 8'h0, 32'h0);
    chk("R10", "done", 32'(done_o), 32'd1);
    chk("R10", "reg_we", 32'(reg_we_o), 32'd0);
    chk("R10", "mem_req", 32'(mem_req_o), 32'd0);
    chk("R10", "illegal", 32'(illegal_o), 32'd0);
  endtask

  task automatic t_busy;
    @(negedge clk_i);
    opcode_i = 4'h1; op0_i = 4'd3; op1_i = 4'd2; op2_i = 4'd4; start_i = 1'b1;
    @(negedge clk_i);                                     // load in progress
    opcode_i = 4'h0; op0_i = 4'd7; ext_i = 32'hDEAD_0000; // stray start
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R12", "waddr", 32'(reg_waddr_o), 32'd4);
    chk("R12", "wdata", reg_wdata_o, 32'h1234_5678);
    @(negedge clk_i);
    chk("R12", "no done", 32'(done_o), 32'd0);
    chk("R12", "no reg_we", 32'(reg_we_o), 32'd0);
    reg_op("R12", 4'h6, 4'd0, 4'd7, 4'd3, 8'h0, 32'h0, 3'd3, 32'hEDCB_A987); // r7 intact
  endtask

  task automatic t_halt;
    issue(4'hF, 4'd0, 4'd0, 4'd0, 8'h0, 32'h0);
    chk("R9", "done", 32'(done_o), 32'd1);
    chk("R9", "reg_we", 32'(reg_we_o), 32'd0);
    @(negedge clk_i);
    chk("R9", "halt", 32'(halt_o), 32'd1);
    issue(4'h0, 4'd3, 4'd0, 4'd0, 8'h0, 32'h5555_5555);
    chk("R9", "ignored done", 32'(done_o), 32'd0);
    chk("R9", "ignored reg_we", 32'(reg_we_o), 32'd0);
    @(negedge clk_i);
    chk("R9", "still halted", 32'(halt_o), 32'd1);
    chk("R9", "still quiet", 32'(reg_we_o), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ldi();
    t_offset();
    t_indexed();
    t_alu();
    bad_op("R7", 4'h6, 4'd8, 4'd1, 4'd2);
    t_shift();
    bad_op("R11", 4'h5, 4'd0, 4'd0, 4'd0);
    bad_op("R11", 4'hC, 4'd0, 4'd0, 4'd0);
    bad_op("R11", 4'h1, 4'd0, 4'd1, 4'd9);
    t_nop();
    t_busy();
    t_halt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule